// File: doc/BRIEF.md
# Coin Credit Dispense Controller

This block counts credit from three coin push-buttons and raises a dispense flag once the credit reaches the price. The coins are worth 5, 10 and 25 cents, and the price is 50 cents. Each button arrives as a raw level that can change at any time. The block synchronises each button to the clock. It accepts a press only on a low-to-high transition, so a button held for millions of cycles adds its value a single time.

Credit moves in 5-cent steps and saturates at 50. Once full, the controller holds its credit and the dispense flag and takes no further coins until a synchronous reset. The credit and the dispense flag are plain registered status outputs. They have no handshake, because no data stream passes through the block.

Top module: `coin_credit_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the edge clears `credit` to 0 and `dispense` to 0.
- R2: A press on `coin_raw[0]` adds 5 to the credit, a press on `coin_raw[1]` adds 10, and a press on `coin_raw[2]` adds 25. `credit` is a 6-bit unsigned count of cents and is always a multiple of 5.
- R3: A press that would take the credit above 50 leaves it at exactly 50. For example, 30 plus 25 gives 50, and 45 plus 10 gives 50.
- R4: `dispense` is 1 exactly when `credit` equals 50, and it is 0 at every lower credit.
- R5: Once the credit is 50, the block ignores presses on every coin input until reset, so `credit` stays 50 and `dispense` stays 1.
- R6: When presses on several inputs are recognised on the same cycle, only one of them counts. Bit 0 wins over bit 1, and bit 1 wins over bit 2. The losing presses are dropped.
- R7: A button held high for any number of cycles adds its value once. A new value is added only after the button has been released and pressed again.
- R8: A button that is already high when reset is released is not counted. It must first be seen low before a later press is accepted.
- R9: When a raw input goes high before a clock edge, `credit` shows the new value after the third rising edge from and including that edge, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coin_raw | input | 3 | Raw, asynchronous button levels: bit 0 is 5c, bit 1 is 10c, bit 2 is 25c |
| credit | output | 6 | Registered credit in cents |
| dispense | output | 1 | Registered flag, high while the credit is full |

## Verification
The assertions assume that `rst` is synchronous and is high on the first sampled edge. They also assume that each button level, once changed, stays put for at least the depth of the synchroniser, so that no press is narrower than the block can see. The stimulus holds every button level for six cycles and keeps reset high for two edges. It sweeps every start credit from 0 to 45 against every non-empty combination of buttons pressed together, and the expected credit is computed as the lesser of the start plus the highest-priority value and 50.

// File: rtl/coin_credit_pkg.sv
package coin_credit_pkg;
  localparam int NUM_COINS  = 3;
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    COIN_NICKEL  = 2'd0,
    COIN_DIME    = 2'd1,
    COIN_QUARTER = 2'd2
  } coin_idx_e;
endpackage

// File: rtl/coin_press_detect.sv
module coin_press_detect #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic warm,
  input  logic raw_in,
  output logic press
);
  logic [SYNC_DEPTH-1:0] sync_q;
  logic                  prev_q;
  logic                  armed_q;
  logic                  level;

  assign level = sync_q[SYNC_DEPTH-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_DEPTH-2:0], raw_in};
      prev_q  <= level;
      if (warm && !level) armed_q <= 1'b1;
    end
  end

  assign press = armed_q && level && !prev_q;
endmodule

// File: rtl/coin_accum.sv
module coin_accum #(
  parameter int CREDIT_W  = 6,
  parameter int VAL_LO    = 5,
  parameter int VAL_MID   = 10,
  parameter int VAL_HI    = 25,
  parameter int FULL_AT   = 50
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          press,
  output logic [CREDIT_W-1:0] credit,
  output logic                dispense
);
  localparam int SUM_W = CREDIT_W + 1;
  localparam logic [SUM_W-1:0] FULL_S = SUM_W'(FULL_AT);

  logic [SUM_W-1:0]    add_val;
  logic [SUM_W-1:0]    sum;
  logic [CREDIT_W-1:0] credit_nx;
  logic                full;

  assign full = (credit == CREDIT_W'(FULL_AT));

  always_comb begin
    if (press[0])      add_val = SUM_W'(VAL_LO);
    else if (press[1]) add_val = SUM_W'(VAL_MID);
    else if (press[2]) add_val = SUM_W'(VAL_HI);
    else               add_val = '0;
    sum = {1'b0, credit} + add_val;
    if (full)             credit_nx = credit;
    else if (sum > FULL_S) credit_nx = CREDIT_W'(FULL_AT);
    else                   credit_nx = sum[CREDIT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      credit   <= '0;
      dispense <= 1'b0;
    end else begin
      credit   <= credit_nx;
      dispense <= (credit_nx == CREDIT_W'(FULL_AT));
    end
  end
endmodule

// File: rtl/coin_credit_ctrl.sv
module coin_credit_ctrl
  import coin_credit_pkg::*;
#(
  parameter int CREDIT_W = 6,
  parameter int VAL_LO   = 5,
  parameter int VAL_MID  = 10,
  parameter int VAL_HI   = 25,
  parameter int FULL_AT  = 50
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          coin_raw,
  output logic [CREDIT_W-1:0] credit,
  output logic                dispense
);
  localparam int WARM_W = $clog2(SYNC_DEPTH + 1);

  logic [WARM_W-1:0]    warm_cnt;
  logic                 warm;
  logic [NUM_COINS-1:0] press;

  assign warm = (warm_cnt == WARM_W'(SYNC_DEPTH));

  always_ff @(posedge clk) begin
    if (rst)        warm_cnt <= '0;
    else if (!warm) warm_cnt <= warm_cnt + 1'b1;
  end

  for (genvar g = 0; g < NUM_COINS; g++) begin : g_btn
    coin_press_detect #(.SYNC_DEPTH(SYNC_DEPTH)) det_i (
      .clk    (clk),
      .rst    (rst),
      .warm   (warm),
      .raw_in (coin_raw[g]),
      .press  (press[g])
    );
  end

  coin_accum #(
    .CREDIT_W (CREDIT_W),
    .VAL_LO   (VAL_LO),
    .VAL_MID  (VAL_MID),
    .VAL_HI   (VAL_HI),
    .FULL_AT  (FULL_AT)
  ) acc_i (
    .clk      (clk),
    .rst      (rst),
    .press    (press),
    .credit   (credit),
    .dispense (dispense)
  );
endmodule

// File: rtl/coin_credit_chk.sv
module coin_credit_chk #(
  parameter int CREDIT_W = 6,
  parameter int FULL_AT  = 50
) (
  input logic                clk,
  input logic                rst,
  input logic [CREDIT_W-1:0] credit,
  input logic                dispense
);
  localparam logic [CREDIT_W-1:0] FULL_C = CREDIT_W'(FULL_AT);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (credit == '0 && !dispense));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    credit <= FULL_C);

  // R4
  dispense_match_chk: assert property (@(posedge clk) disable iff (rst)
    dispense == (credit == FULL_C));

  // R5
  full_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (credit == FULL_C) |=> (credit == FULL_C));

  // R2
  step_size_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && credit != $past(credit)) |->
      (credit == FULL_C || credit - $past(credit) == 5 ||
       credit - $past(credit) == 10 || credit - $past(credit) == 25));

  // R2
  multiple_of_five_chk: assert property (@(posedge clk) disable iff (rst)
    (credit % 5) == 0);
endmodule

bind coin_credit_ctrl coin_credit_chk #(.CREDIT_W(CREDIT_W), .FULL_AT(FULL_AT)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .credit   (credit),
  .dispense (dispense)
);

// File: tb/coin_credit_ctrl_tb_top.sv
`timescale 1ns/1ps
module coin_credit_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] coin_raw = 3'b000;
  logic [5:0] credit;
  logic       dispense;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  coin_credit_ctrl dut_i (
    .clk(clk), .rst(rst), .coin_raw(coin_raw),
    .credit(credit), .dispense(dispense)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cycles(2);
    rst = 1'b0;
    cycles(5);
  endtask

  task automatic press(input logic [2:0] m, input int hold);
    coin_raw = m;
    cycles(hold);
    coin_raw = 3'b000;
    cycles(6);
  endtask

  function automatic int coin_val(input logic [2:0] m);
    if (m[0]) return 5;
    if (m[1]) return 10;
    return 25;
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int exp;
    cycles(3);
    rst = 1'b0;
    cycles(1);
    rst = 1'b1;
    cycles(1);
    check("R1 credit after reset", credit, 0);
    check("R1 dispense after reset", dispense, 0);
    rst = 1'b0;
    cycles(5);

    // R2 R3 R4 R6: every start level against every button combination
    for (int lvl = 0; lvl <= 45; lvl += 5) begin
      for (int m = 1; m < 8; m++) begin
        do_reset();
        for (int k = 0; k < lvl / 5; k++) press(3'b001, 6);
        check("R2 build-up", credit, lvl);
        press(3'(m), 6);
        exp = lvl + coin_val(3'(m));
        if (exp > 50) exp = 50;
        check(m == 1 || m == 2 || m == 4 ? "R2/R3 single coin" : "R6 priority", credit, exp);
        check("R4 dispense", dispense, exp == 50);
      end
    end

    // R9 latency
    do_reset();
    @(negedge clk);
    coin_raw = 3'b010;
    cycles(2);
    check("R9 unchanged after two edges", credit, 0);
    cycles(1);
    check("R9 updated after third edge", credit, 10);
    coin_raw = 3'b000;
    cycles(6);

    // R7 long hold
    do_reset();
    press(3'b100, 3000);
    check("R7 long hold counts once", credit, 25);
    press(3'b100, 6);
    check("R7 repress counts again", credit, 50);
    check("R4 dispense at full", dispense, 1);

    // R5 ignore when full
    for (int m = 1; m < 8; m++) begin
      press(3'(m), 6);
      check("R5 full ignores coins", credit, 50);
      check("R5 dispense stays", dispense, 1);
    end

    // R8 held across reset
    do_reset();
    coin_raw = 3'b100;
    rst = 1'b1;
    cycles(2);
    rst = 1'b0;
    cycles(20);
    check("R8 held through reset not counted", credit, 0);
    coin_raw = 3'b000;
    cycles(6);
    check("R8 release not counted", credit, 0);
    press(3'b100, 6);
    check("R8 next press counted", credit, 25);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule